// File: doc/BRIEF.md
# Auto-Reload Binary Up Counter

This block is a synchronous binary up counter that restarts from a parallel preset word each time it wraps. Counting uses parallel-carry toggle logic: the lowest bit flips on every clock edge, and every higher bit flips when all bits below it are one. When the count reaches all ones, the next edge loads the preset input instead of rolling over to zero. Counting then resumes upward from the loaded value.

The active-low terminal-count output is not decoded from the count. It is a flip-flop that is set one cycle ahead. While counting, it is set from the "all ones except the lowest bit" state. While a reload is taking place, it is set from the preset word. This keeps the wide all-ones compare out of the path that selects between incrementing and reloading. A synchronous reset clears the count and leaves the terminal-count flag inactive.

Top module: `reload_ctr`

## Requirements
- R1: On a clock edge with `rst` high, `count` becomes zero and `tc_n` becomes 1.
- R2: While `tc_n` is 1, bit 0 of `count` inverts on every rising edge.
- R3: While `tc_n` is 1, bit i (i>0) of `count` inverts on a rising edge exactly when bits i-1..0 are all one. The count therefore advances by one.
- R4: Outside reset, `tc_n` is 0 in exactly those cycles in which every bit of `count` is one.
- R5: While `tc_n` is 0, the next rising edge loads `count` with the value of `preset` at that edge.
- R6: While `tc_n` is 1, changes on `preset` have no effect on `count` or `tc_n`.
- R7: If the loaded preset is all ones, `tc_n` stays 0 for the following cycle and the preset is loaded again.
- R8: A preset that changes from cycle to cycle is loaded with the value present at the reload edge, not an earlier one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| preset | input | W | Value loaded on the edge after terminal count |
| count | output | W | Current count |
| tc_n | output | 1 | Terminal count, low while `count` is all ones |

## Verification
The counter runs through complete wraps with three kinds of preset:
- A mid-range preset (F0h). This shows that the reload goes to the preset and not to zero.
- A zero preset. This gives a full 256-state cycle, so every carry length occurs.
- Presets of FFh and FEh. These separate a flag that is predicted from the preset from one that is predicted only from the counting path.

A final phase changes the preset on every cycle. This shows that the preset is ignored while counting and is sampled only on the reload edge. A reset issued in the middle of the run checks the return to the cleared state.

// File: rtl/reload_ctr.sv
module reload_ctr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] preset,
  output logic [W-1:0] count,
  output logic         tc_n
);

  localparam logic [W-1:0] NEAR_END = {{(W-1){1'b1}}, 1'b0};

  logic [W-1:0] flip_mask;
  logic [W-1:0] next_count;
  logic         tc_n_next;

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_carry
      if (i == 0) begin : g_lsb
        assign flip_mask[i] = 1'b1;
      end else begin : g_upper
        assign flip_mask[i] = &count[i-1:0];
      end
    end
  endgenerate

  assign next_count = tc_n ? (count ^ flip_mask) : preset;
  assign tc_n_next  = tc_n ? (count != NEAR_END) : ~(&preset);

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      tc_n  <= 1'b1;
    end else begin
      count <= next_count;
      tc_n  <= tc_n_next;
    end
  end

endmodule

// File: rtl/reload_ctr_chk.sv
module reload_ctr_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] preset,
  input logic [W-1:0] count,
  input logic         tc_n
);

  logic armed;
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b1;
  end

  // R1
  reset_state_chk: assert property (@(posedge clk)
    (armed && $past(rst)) |-> (count == '0 && tc_n));

  // R2
  lsb_flip_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && tc_n) |=> (count[0] != $past(count[0])));

  // R3
  increment_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && tc_n) |=> (count == $past(count) + 1'b1));

  // R4
  tc_match_chk: assert property (@(posedge clk) disable iff (rst)
    armed |-> (tc_n == (count != '1)));

  // R5
  reload_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && !tc_n) |=> (count == $past(preset)));

  // R7
  full_preset_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && !tc_n && (&preset)) |=> !tc_n);

endmodule

bind reload_ctr reload_ctr_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .preset(preset), .count(count), .tc_n(tc_n)
);

// File: tb/reload_ctr_test.sv
module reload_ctr_test;
  localparam int W = 8;
  localparam int PERIOD = 10;
  localparam logic [W-1:0] MAXV = '1;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] preset = '0;
  logic [W-1:0] count;
  logic         tc_n;

  int total = 0;
  int fails = 0;
  bit started = 1'b0;

  logic [W-1:0] m_cnt, m_prev, last_preset;
  logic         m_tc_n;
  string        tag;

  reload_ctr #(.W(W)) uut (
    .clk(clk), .rst(rst), .preset(preset), .count(count), .tc_n(tc_n)
  );

  always #(PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    m_prev = m_cnt;
    if (rst) begin
      m_cnt = '0;
      tag = "R1";
    end else if (m_cnt == MAXV) begin
      m_cnt = preset;
      if (preset == MAXV) tag = "R7";
      else if (preset != last_preset) tag = "R8";
      else tag = "R5";
    end else begin
      m_cnt = m_cnt + 1'b1;
      tag = (preset != last_preset) ? "R6" : "R3";
    end
    m_tc_n = rst ? 1'b1 : (m_cnt != MAXV);
    last_preset = preset;
    started = 1'b1;
  end

  task automatic check(input bit ok, input string req,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      check(count === m_cnt, tag, count, m_cnt);
      check(tc_n === m_tc_n, (tag == "R1") ? "R1" : "R4",
            {{(W-1){1'b0}}, tc_n}, {{(W-1){1'b0}}, m_tc_n});
      if (tag == "R3" || tag == "R6")
        check(count[0] !== m_prev[0], "R2",
              {{(W-1){1'b0}}, count[0]}, {{(W-1){1'b0}}, ~m_prev[0]});
    end
  end

  task automatic run(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    logic [15:0] lfsr;
    lfsr = 16'hACE1;
    run(3);
    rst = 1'b0;
    preset = 8'hF0;
    run(300);
    preset = 8'hFF;
    run(12);
    preset = 8'hFE;
    run(12);
    preset = 8'h00;
    run(300);
    for (int k = 0; k < 600; k++) begin
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      preset = lfsr[7:0] | 8'hC0;
    end
    preset = 8'h10;
    rst = 1'b1;
    run(1);
    rst = 1'b0;
    run(40);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #(PERIOD * 200000);
    total++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule